// File: doc/BRIEF.md
# Page Write Load Sequencer

This block is the write-side controller of a byte-alterable parallel nonvolatile memory, modelled with a clock. A host presents byte loads, each one an address and a data byte on a synchronous write strobe. The first accepted load opens a page. The upper address bits pick the page and the low seven bits pick the byte inside it. Further loads into the same page are gathered in a page buffer. A per-byte valid mask records which locations were written.

The page stays open as long as every new accepted load arrives within a fixed window of clock cycles after the previous accepted load. The total number of loads has no limit. When the window runs out, the block enters a self-timed programming phase of fixed length and raises `busy`. During that phase it walks the page once, in ascending offset order, and hands every loaded byte to a behavioural array over a one-byte-per-cycle commit port. At the end of the phase it clears the buffer and the mask.

A load whose page differs from the open page is dropped and counted. Write strobes during programming are ignored.

Top module: `page_load_seq`

## Requirements
- R1: After reset, `busy`, `page_err` and `commit_en` are 0 and `err_cnt` is 0.
- R2: A cycle is a byte load only when `chip_sel`=1, `wr_stb`=1 and `out_en`=0. A cycle with any other combination stores nothing, opens no page and leaves no trace in later commits.
- R3: In the idle state, a load opens a page. The page number is `addr[14:7]` and the byte offset is `addr[6:0]`.
- R4: Each accepted load restarts the window. A load sampled WIN_CYC cycles after the previous accepted load is still accepted. If no accepted load arrives in those WIN_CYC cycles, `busy` rises at the clock edge that ends the WIN_CYC-th cycle.
- R5: A page load may run for any number of loads. A byte loaded twice at the same offset is committed with the data of its last load.
- R6: A load whose `addr[14:7]` differs from the open page is not stored and does not restart the window. One cycle later it pulses `page_err`, and it increments `err_cnt`, which saturates at 2^ERR_W-1.
- R7: `busy` stays high for exactly PROG_CYC consecutive cycles.
- R8: Write strobes sampled while `busy` is high are ignored.
- R9: While `busy`, exactly one `commit_en` cycle is issued per loaded offset. The commits come in ascending offset order, with `commit_addr` = {page, offset} and `commit_data` = the stored byte. Offsets that were not loaded are never committed.
- R10: After programming ends, the buffer is empty: the next page commits only its own bytes.
- R11: Inhibited cycles between loads, such as host reads with `out_en`=1, do not close the page while the gaps between accepted loads stay within the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel | input | 1 | Device select, active high |
| wr_stb | input | 1 | Write strobe, active high; one cycle is one load |
| out_en | input | 1 | Output enable, active high; inhibits writes |
| addr | input | 15 | Byte address: page in [14:7], offset in [6:0] |
| wdata | input | 8 | Load data |
| busy | output | 1 | Internal programming in progress |
| page_err | output | 1 | One-cycle pulse after a load with a foreign page |
| err_cnt | output | 4 | Saturating count of foreign-page loads |
| commit_en | output | 1 | Commit write to the array this cycle |
| commit_addr | output | 15 | Array address of the commit |
| commit_data | output | 8 | Data of the commit |

## Verification
The bench aims at the window boundary from both sides. A load exactly WIN_CYC cycles after its predecessor must join the same page. One cycle later, the same load must be swallowed by the busy phase. A design that is off by one there would either split the page or take a load while busy. Foreign-page loads are placed so that they would stretch the window if they wrongly restarted it, and so that a design which stored them would commit a wrong byte. Long pages with repeated offsets and interleaved read cycles expose a design that keeps the first data instead of the last, closes the page on a read, or fails to clear its mask between pages.

// File: rtl/pls_pkg.sv
package pls_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } seq_state_e;

endpackage

// File: rtl/pls_window.sv
module pls_window #(
  parameter int WIN_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expired
);

  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(WIN_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)
      cnt_d = RELOAD;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/pls_page_buf.sv
module pls_page_buf #(
  parameter int OFS_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [OFS_W-1:0]  rd_ofs,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld,
  output logic              any_vld
);

  localparam int NBYTES = 1 << OFS_W;

  logic [DATA_W-1:0] mem_q [NBYTES];
  logic [NBYTES-1:0] mask_q, mask_d;

  generate
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      logic hit;
      assign hit = wr_en && (wr_ofs == OFS_W'(i));

      always_ff @(posedge clk) begin
        if (hit)
          mem_q[i] <= wr_data;
      end

      always_comb begin
        if (clr)
          mask_d[i] = 1'b0;
        else
          mask_d[i] = mask_q[i] | hit;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= '0;
    else
      mask_q <= mask_d;
  end

  assign rd_data = mem_q[rd_ofs];
  assign rd_vld  = mask_q[rd_ofs];
  assign any_vld = |mask_q;

endmodule

// File: rtl/pls_prog_engine.sv
module pls_prog_engine #(
  parameter int PROG_CYC = 160,
  parameter int OFS_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             running,
  output logic             scan_vld,
  output logic [OFS_W-1:0] scan_ofs,
  output logic             done
);

  localparam int CNT_W = $clog2(PROG_CYC + 1);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] SCAN_END = CNT_W'(1 << OFS_W);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (start) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (run_q) begin
      if (cnt_q == LAST) begin
        run_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign running  = run_q;
  assign done     = run_q && (cnt_q == LAST);
  assign scan_vld = run_q && (cnt_q < SCAN_END);
  assign scan_ofs = cnt_q[OFS_W-1:0];

  // R7
  run_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(start));

  // R7
  stop_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !run_q);

endmodule

// File: rtl/page_load_seq.sv
module page_load_seq #(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8,
  parameter int OFS_W    = 7,
  parameter int WIN_CYC  = 16,
  parameter int PROG_CYC = 160,
  parameter int ERR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel,
  input  logic              wr_stb,
  input  logic              out_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              page_err,
  output logic [ERR_W-1:0]  err_cnt,
  output logic              commit_en,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);

  import pls_pkg::*;

  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  seq_state_e        state_q, state_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [ERR_W-1:0]  err_q, err_d;
  logic              perr_q;

  logic load_q, page_hit, accept, mis;
  logic buf_wr, buf_clr, win_restart, win_exp;
  logic prog_start, prog_run, prog_done, scan_vld;
  logic [OFS_W-1:0]  scan_ofs;
  logic [DATA_W-1:0] rd_data;
  logic rd_vld, buf_any;

  assign load_q   = chip_sel && wr_stb && !out_en;
  assign page_hit = (addr[ADDR_W-1:OFS_W] == page_q);
  assign accept   = load_q && page_hit;

  always_comb begin
    state_d     = state_q;
    page_d      = page_q;
    buf_wr      = 1'b0;
    buf_clr     = 1'b0;
    win_restart = 1'b0;
    prog_start  = 1'b0;
    mis         = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (load_q) begin
          buf_wr      = 1'b1;
          win_restart = 1'b1;
          page_d      = addr[ADDR_W-1:OFS_W];
          state_d     = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (accept) begin
          buf_wr      = 1'b1;
          win_restart = 1'b1;
        end else begin
          mis = load_q;
          if (win_exp) begin
            prog_start = 1'b1;
            state_d    = ST_PROG;
          end
        end
      end
      ST_PROG: begin
        if (prog_done) begin
          buf_clr = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    err_d = err_q;
    if (mis && (err_q != ERR_MAX))
      err_d = err_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      err_q   <= '0;
      perr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      page_q  <= page_d;
      err_q   <= err_d;
      perr_q  <= mis;
    end
  end

  pls_window #(.WIN_CYC(WIN_CYC)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (win_restart),
    .expired (win_exp)
  );

  pls_page_buf #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (buf_wr),
    .wr_ofs  (addr[OFS_W-1:0]),
    .wr_data (wdata),
    .clr     (buf_clr),
    .rd_ofs  (scan_ofs),
    .rd_data (rd_data),
    .rd_vld  (rd_vld),
    .any_vld (buf_any)
  );

  pls_prog_engine #(.PROG_CYC(PROG_CYC), .OFS_W(OFS_W)) u_prog (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (prog_start),
    .running  (prog_run),
    .scan_vld (scan_vld),
    .scan_ofs (scan_ofs),
    .done     (prog_done)
  );

  assign busy        = prog_run;
  assign page_err    = perr_q;
  assign err_cnt     = err_q;
  assign commit_en   = scan_vld && rd_vld;
  assign commit_addr = {page_q, scan_ofs};
  assign commit_data = rd_data;

  // R8
  no_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |-> !prog_run);

  // R4
  expire_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD && !accept && win_exp) |=> prog_run);

  // R9
  commit_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |-> busy);

  // R10
  buf_empty_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> !buf_any);

  // R6
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |-> ($past(err_q) == ERR_MAX || err_q == $past(err_q) + 1'b1));

endmodule

// File: tb/page_load_seq_tb.sv
module page_load_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WIN_CYC    = 16;
  localparam int PROG_CYC   = 160;
  localparam int ERR_MAX    = 15;

  logic        clk;
  logic        rst_n;
  logic        chip_sel, wr_stb, out_en;
  logic [14:0] addr;
  logic [7:0]  wdata;
  logic        busy, page_err, commit_en;
  logic [3:0]  err_cnt;
  logic [14:0] commit_addr;
  logic [7:0]  commit_data;

  int checks, fails, exp_err;
  bit finished;

  int          log_n;
  logic [14:0] log_addr [1024];
  logic [7:0]  log_data [1024];

  page_load_seq #(
    .WIN_CYC  (WIN_CYC),
    .PROG_CYC (PROG_CYC)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .chip_sel    (chip_sel),
    .wr_stb      (wr_stb),
    .out_en      (out_en),
    .addr        (addr),
    .wdata       (wdata),
    .busy        (busy),
    .page_err    (page_err),
    .err_cnt     (err_cnt),
    .commit_en   (commit_en),
    .commit_addr (commit_addr),
    .commit_data (commit_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && commit_en && log_n < 1024) begin
      log_addr[log_n] = commit_addr;
      log_data[log_n] = commit_data;
      log_n = log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // drives one cycle starting at a negedge, returns at the next negedge
  task automatic strobe(input logic cs, input logic we, input logic oe,
                        input logic [14:0] a, input logic [7:0] d);
    chip_sel = cs; wr_stb = we; out_en = oe; addr = a; wdata = d;
    @(negedge clk);
    chip_sel = 1'b0; wr_stb = 1'b0; out_en = 1'b0;
  endtask

  task automatic load(input logic [14:0] a, input logic [7:0] d);
    strobe(1'b1, 1'b1, 1'b0, a, d);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_prog(output int cyc);
    cyc = 0;
    while (!busy && cyc < 4 * WIN_CYC) begin idle(1); cyc++; end
    cyc = 0;
    while (busy && cyc < 4 * PROG_CYC) begin idle(1); cyc++; end
  endtask

  task automatic t_reset();
    chk(busy == 0 && page_err == 0 && commit_en == 0 && err_cnt == 0, "R1",
        {busy, page_err, commit_en, err_cnt}, 0);
  endtask

  task automatic t_single_timing();
    int base, cyc;
    base = log_n;
    load(15'h1234, 8'h5A);
    idle(WIN_CYC - 1);
    chk(busy == 0, "R4 before window end", busy, 0);
    idle(1);
    chk(busy == 1, "R4 at window end", busy, 1);
    cyc = 1;
    while (busy && cyc < 4 * PROG_CYC) begin idle(1); if (busy) cyc++; end
    chk(cyc == PROG_CYC, "R7 busy length", cyc, PROG_CYC);
    chk(log_n - base == 1, "R3 commit count", log_n - base, 1);
    chk(log_addr[base] == 15'h1234 && log_data[base] == 8'h5A, "R3 R9 commit addr/data",
        {log_addr[base], log_data[base]}, {15'h1234, 8'h5A});
  endtask

  task automatic t_window_edge();
    int base, cyc;
    base = log_n;
    load(15'h0A05, 8'h11);
    idle(WIN_CYC - 1);
    load(15'h0A09, 8'h22);
    chk(busy == 0, "R4 load at last window cycle kept page", busy, 0);
    wait_prog(cyc);
    chk(log_n - base == 2, "R4 both bytes in one page", log_n - base, 2);
    chk(log_addr[base] == 15'h0A05 && log_addr[base+1] == 15'h0A09, "R9 ascending order",
        log_addr[base+1], 15'h0A09);
    base = log_n;
    load(15'h0B01, 8'h33);
    idle(WIN_CYC);
    load(15'h0B02, 8'h44);
    chk(busy == 1, "R8 busy when late load arrives", busy, 1);
    wait_prog(cyc);
    idle(2);
    chk(log_n - base == 1, "R8 late load during busy ignored", log_n - base, 1);
    chk(busy == 0, "R8 no new page opened by ignored load", busy, 0);
  endtask

  task automatic t_long_page();
    int base, cyc, o;
    logic [7:0] e;
    base = log_n;
    for (int i = 0; i < 200; i++) begin
      load({8'h55, 7'(i % 128)}, 8'(i));
      if (i % 3 == 0) strobe(1'b1, 1'b1, 1'b1, {8'h55, 7'(i % 128)}, 8'hEE);
      if (i % 5 == 0) strobe(1'b0, 1'b1, 1'b0, {8'h55, 7'(i % 128)}, 8'hDD);
    end
    chk(busy == 0, "R11 reads did not close page", busy, 0);
    wait_prog(cyc);
    chk(log_n - base == 128, "R5 full page commit count", log_n - base, 128);
    for (int k = 0; k < 128; k++) begin
      o = k;
      e = (o < 72) ? 8'(o + 128) : 8'(o);
      chk(log_addr[base+k] == {8'h55, 7'(o)} && log_data[base+k] == e,
          "R5 R9 last data per offset", log_data[base+k], e);
    end
  endtask

  task automatic t_mismatch();
    int base, cyc;
    base = log_n;
    load(15'h0C03, 8'hA1);
    load(15'h0D03, 8'hB2);
    exp_err = (exp_err < ERR_MAX) ? exp_err + 1 : ERR_MAX;
    chk(page_err == 1, "R6 page_err pulse", page_err, 1);
    chk(err_cnt == exp_err, "R6 err count", err_cnt, exp_err);
    idle(1);
    chk(page_err == 0, "R6 page_err one cycle", page_err, 0);
    idle(WIN_CYC - 3);
    chk(busy == 0, "R6 window from last good load", busy, 0);
    idle(1);
    chk(busy == 1, "R6 foreign load did not restart window", busy, 1);
    wait_prog(cyc);
    chk(log_n - base == 1 && log_data[base] == 8'hA1, "R6 foreign byte not stored",
        log_data[base], 8'hA1);
  endtask

  task automatic t_saturate();
    int base, cyc;
    base = log_n;
    for (int j = 0; j < 20; j++) begin
      load({8'h20, 7'(j)}, 8'(j + 1));
      load({8'h21, 7'(j)}, 8'hFF);
    end
    exp_err = ERR_MAX;
    chk(err_cnt == ERR_MAX, "R6 err count saturates", err_cnt, ERR_MAX);
    wait_prog(cyc);
    chk(log_n - base == 20, "R6 only own page committed", log_n - base, 20);
  endtask

  task automatic t_inhibit();
    int base;
    base = log_n;
    strobe(1'b0, 1'b1, 1'b0, 15'h0100, 8'h01);
    strobe(1'b1, 1'b0, 1'b0, 15'h0101, 8'h02);
    strobe(1'b1, 1'b1, 1'b1, 15'h0102, 8'h03);
    strobe(1'b0, 1'b0, 1'b1, 15'h0103, 8'h04);
    idle(WIN_CYC + 4);
    chk(busy == 0, "R2 inhibited strobes start nothing", busy, 0);
    chk(log_n - base == 0, "R2 inhibited strobes commit nothing", log_n - base, 0);
  endtask

  task automatic t_clear();
    int base, cyc;
    load(15'h3F01, 8'h77);
    wait_prog(cyc);
    base = log_n;
    load(15'h4002, 8'h88);
    wait_prog(cyc);
    chk(log_n - base == 1, "R10 buffer cleared between pages", log_n - base, 1);
    chk(log_addr[base] == 15'h4002 && log_data[base] == 8'h88, "R10 new page only",
        log_addr[base], 15'h4002);
  endtask

  initial begin
    checks = 0; fails = 0; exp_err = 0; log_n = 0; finished = 0;
    chip_sel = 0; wr_stb = 0; out_en = 0; addr = '0; wdata = '0;
    rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(1);
    t_reset();
    t_single_timing();
    t_window_edge();
    t_long_page();
    t_mismatch();
    t_saturate();
    t_inhibit();
    t_clear();
    finished = 1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      report();
      $finish;
    end
  end

endmodule